// File: doc/BRIEF.md
# Bidirectional Latch/Register Bus Transceiver

This block carries an 18-bit word in each of two directions between port A and port B. The A-to-B path and the B-to-A path each have their own storage element and four controls: a latch enable, a transfer clock, an active-low clock enable and an active-low output enable. When its latch enable is high, a path is transparent and its output follows its input. When the latch enable is low, the path holds its stored word. It loads a new word only on a rising edge of its transfer clock, and only while its clock enable is asserted.

Everything runs on one free-running system clock. Each path registers its data, its controls and its transfer clock once on that clock. It finds transfer-clock edges by comparing that registered sample with the sample from the cycle before. The capture takes the data word registered in the same cycle as the high clock sample, so a word present when the transfer clock rises is the one stored. Each output port drives a data word and a drive flag that stands in for a tri-state pin. While the port is disabled, the data word is forced to zero.

Top module: `bus_xcvr`

## Requirements
- R1: Both directions are 18 bits wide by default and act independently; controls of one direction never change the other direction's output.
- R2: With the latch enable high and the output enabled, the output data equals the input word applied one system-clock cycle earlier.
- R3: With the latch enable low and no rising transfer-clock edge, the stored word and the output stay unchanged whatever the input data does.
- R4: With the latch enable low and the clock enable low, a rising edge of the transfer clock stores the input word present in the cycle the clock was first sampled high; the output shows it one cycle after that.
- R5: The clock enable is active low: a rising transfer-clock edge sampled while it is high leaves storage unchanged.
- R6: When the latch enable goes from high to low, storage keeps the last word passed through in transparent mode.
- R7: The output enable is active low. While it is high, the drive flag is 0 and the output data is all zeros, and storage still captures. When it is driven low again, the stored word appears.
- R8: While reset is asserted and after it, both storage registers are zero and both drive flags are 0 (1 means driving).
- R9: A falling edge of the transfer clock never changes storage.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| a_i | input | 18 | Port A input data |
| ab_le_i | input | 1 | A-to-B latch enable (1 = transparent) |
| ab_xclk_i | input | 1 | A-to-B transfer clock |
| ab_cken_ni | input | 1 | A-to-B clock enable, active low |
| ab_oe_ni | input | 1 | A-to-B output enable, active low |
| b_i | input | 18 | Port B input data |
| ba_le_i | input | 1 | B-to-A latch enable (1 = transparent) |
| ba_xclk_i | input | 1 | B-to-A transfer clock |
| ba_cken_ni | input | 1 | B-to-A clock enable, active low |
| ba_oe_ni | input | 1 | B-to-A output enable, active low |
| b_o | output | 18 | Port B output data, zero when not driving |
| b_drive_o | output | 1 | Port B drive flag (1 = driving) |
| a_o | output | 18 | Port A output data, zero when not driving |
| a_drive_o | output | 1 | Port A drive flag (1 = driving) |

## Verification
Two functions can fall in the same cycle: a capture on a transfer-clock rising edge, and the output being disabled. The same goes for a capture and the latch enable going low. The bench raises the A-to-B transfer clock while that port's output enable is high, and checks that B reads zero with the drive flag low. It then re-enables the port and checks that the captured word appears. In a separate step, the latch enable drops in the same cycle as a clock rise, and the bench checks which word storage keeps.

// File: rtl/xcvr_pkg.sv
package xcvr_pkg;
  localparam int unsigned DEF_WIDTH = 18;
  localparam int unsigned NUM_DIR   = 2;
  localparam int unsigned DIR_AB    = 0;
  localparam int unsigned DIR_BA    = 1;

  typedef struct packed {
    logic le;
    logic xclk;
    logic cken_n;
    logic oe_n;
  } lane_ctrl_t;
endpackage

// File: rtl/xfer_edge_det.sv
module xfer_edge_det (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic lvl_i,
  output logic rise_o
);
  logic smp_q, prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      smp_q  <= 1'b0;
      prev_q <= 1'b0;
    end else begin
      smp_q  <= lvl_i;
      prev_q <= smp_q;
    end
  end

  assign rise_o = smp_q & ~prev_q;

  AST_RISE_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rise_o |=> !rise_o); // R4
endmodule

// File: rtl/xcvr_lane.sv
module xcvr_lane
  import xcvr_pkg::*;
#(
  parameter int unsigned WIDTH = DEF_WIDTH
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] din_i,
  input  lane_ctrl_t       ctrl_i,
  output logic [WIDTH-1:0] dout_o,
  output logic             drive_o
);
  logic [WIDTH-1:0] din_q, store_q;
  logic             le_q, cken_nq, oe_nq;
  logic             rise;

  // inputs sampled on the same edge as the transfer clock
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      din_q   <= '0;
      le_q    <= 1'b0;
      cken_nq <= 1'b1;
      oe_nq   <= 1'b1;
    end else begin
      din_q   <= din_i;
      le_q    <= ctrl_i.le;
      cken_nq <= ctrl_i.cken_n;
      oe_nq   <= ctrl_i.oe_n;
    end
  end

  xfer_edge_det u_edge (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .lvl_i  (ctrl_i.xclk),
    .rise_o (rise)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                   store_q <= '0;
    else if (le_q)                 store_q <= din_q;
    else if (rise && !cken_nq)     store_q <= din_q;
  end

  always_comb begin
    drive_o = ~oe_nq;
    dout_o  = '0;
    if (drive_o) dout_o = le_q ? din_q : store_q;
  end

  AST_HOLD_NO_EDGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!le_q && !rise) |=> $stable(store_q)); // R3
  AST_CAPTURE_EDGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!le_q && rise && !cken_nq) |=> (store_q == $past(din_q))); // R4
  AST_GATED_EDGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!le_q && rise && cken_nq) |=> $stable(store_q)); // R5
  AST_TRANSP_TRACK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    le_q |=> (store_q == $past(din_q))); // R6
  AST_OFF_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(oe_nq) |-> (!drive_o && dout_o == '0)); // R7
endmodule

// File: rtl/bus_xcvr.sv
module bus_xcvr
  import xcvr_pkg::*;
#(
  parameter int unsigned WIDTH = DEF_WIDTH
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] a_i,
  input  logic             ab_le_i,
  input  logic             ab_xclk_i,
  input  logic             ab_cken_ni,
  input  logic             ab_oe_ni,
  input  logic [WIDTH-1:0] b_i,
  input  logic             ba_le_i,
  input  logic             ba_xclk_i,
  input  logic             ba_cken_ni,
  input  logic             ba_oe_ni,
  output logic [WIDTH-1:0] b_o,
  output logic             b_drive_o,
  output logic [WIDTH-1:0] a_o,
  output logic             a_drive_o
);
  logic [WIDTH-1:0] lane_din  [NUM_DIR];
  logic [WIDTH-1:0] lane_dout [NUM_DIR];
  lane_ctrl_t       lane_ctrl [NUM_DIR];
  logic             lane_drv  [NUM_DIR];

  assign lane_din[DIR_AB]  = a_i;
  assign lane_ctrl[DIR_AB] = '{le: ab_le_i, xclk: ab_xclk_i, cken_n: ab_cken_ni, oe_n: ab_oe_ni};
  assign lane_din[DIR_BA]  = b_i;
  assign lane_ctrl[DIR_BA] = '{le: ba_le_i, xclk: ba_xclk_i, cken_n: ba_cken_ni, oe_n: ba_oe_ni};

  for (genvar g = 0; g < NUM_DIR; g++) begin : g_lane
    xcvr_lane #(.WIDTH(WIDTH)) u_lane (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .din_i   (lane_din[g]),
      .ctrl_i  (lane_ctrl[g]),
      .dout_o  (lane_dout[g]),
      .drive_o (lane_drv[g])
    );
  end

  assign b_o       = lane_dout[DIR_AB];
  assign b_drive_o = lane_drv[DIR_AB];
  assign a_o       = lane_dout[DIR_BA];
  assign a_drive_o = lane_drv[DIR_BA];

  AST_RESET_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rst_ni) |-> (!b_drive_o && !a_drive_o)); // R8
endmodule

// File: tb/bus_xcvr_tb.sv
module bus_xcvr_tb;
  localparam int W = 18;
  localparam time CLK_PERIOD = 10ns;
  localparam int WATCHDOG = 5000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [W-1:0] a_i, b_i, a_o, b_o;
  logic ab_le, ab_xclk, ab_cken_n, ab_oe_n;
  logic ba_le, ba_xclk, ba_cken_n, ba_oe_n;
  logic a_drv, b_drv;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  bus_xcvr #(.WIDTH(W)) u_dut (
    .clk_i(clk), .rst_ni(rst_n),
    .a_i(a_i), .ab_le_i(ab_le), .ab_xclk_i(ab_xclk), .ab_cken_ni(ab_cken_n), .ab_oe_ni(ab_oe_n),
    .b_i(b_i), .ba_le_i(ba_le), .ba_xclk_i(ba_xclk), .ba_cken_ni(ba_cken_n), .ba_oe_ni(ba_oe_n),
    .b_o(b_o), .b_drive_o(b_drv), .a_o(a_o), .a_drive_o(a_drv)
  );

  typedef struct {
    logic [W-1:0] b_d;
    logic         b_en;
    logic [W-1:0] a_d;
    logic         a_en;
    string        tag;
  } exp_t;
  exp_t sb_q[$];

  // bench model, index 0 = A to B, 1 = B to A
  logic [W-1:0] m_st[2], m_pd[2];
  logic m_ple[2], m_pxc[2], m_ppxc[2], m_pckn[2];

  // ctrl nibble: [0] le, [1] xclk, [2] cken_n, [3] oe_n
  localparam logic [3:0] IDLE = 4'b1100;

  function automatic void model_dir(input int k, input logic [W-1:0] d, input logic [3:0] c,
                                    output logic [W-1:0] od, output logic oe);
    if (m_ple[k]) m_st[k] = m_pd[k];
    else if (m_pxc[k] && !m_ppxc[k] && !m_pckn[k]) m_st[k] = m_pd[k];
    oe = ~c[3];
    od = oe ? (c[0] ? d : m_st[k]) : '0;
    m_ppxc[k] = m_pxc[k];
    m_pxc[k]  = c[1];
    m_ple[k]  = c[0];
    m_pckn[k] = c[2];
    m_pd[k]   = d;
  endfunction

  task automatic step(input logic [W-1:0] av, input logic [3:0] abc,
                      input logic [W-1:0] bv, input logic [3:0] bac, input string tag);
    exp_t e;
    @(negedge clk);
    a_i = av; {ab_oe_n, ab_cken_n, ab_xclk, ab_le} = abc;
    b_i = bv; {ba_oe_n, ba_cken_n, ba_xclk, ba_le} = bac;
    model_dir(0, av, abc, e.b_d, e.b_en);
    model_dir(1, bv, bac, e.a_d, e.a_en);
    e.tag = tag;
    sb_q.push_back(e);
  endtask

  task automatic check(input string tag, input logic [W:0] act, input logic [W:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual drive/data=%0h expected %0h", tag, act, exp);
    end
  endtask

  // monitor
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (sb_q.size() > 0) begin
        exp_t e;
        e = sb_q.pop_front();
        check({e.tag, " port B"}, {b_drv, b_o}, {e.b_en, e.b_d});
        check({e.tag, " port A"}, {a_drv, a_o}, {e.a_en, e.a_d});
      end
    end
  end

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual hung, expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    for (int k = 0; k < 2; k++) begin
      m_st[k] = '0; m_pd[k] = '0; m_ple[k] = 0; m_pxc[k] = 0; m_ppxc[k] = 0; m_pckn[k] = 1;
    end
    a_i = '0; b_i = '0;
    {ab_oe_n, ab_cken_n, ab_xclk, ab_le} = IDLE;
    {ba_oe_n, ba_cken_n, ba_xclk, ba_le} = IDLE;
    repeat (3) @(posedge clk);
    #2;
    check("R8 reset port B", {b_drv, b_o}, '0);
    check("R8 reset port A", {a_drv, a_o}, '0);
    @(negedge clk);
    rst_n = 1'b1;

    // storage zero after reset, inputs changing, latch low, no edge
    step(18'h3FFFF, 4'b0000, 18'h2AAAA, 4'b0000, "R8 storage zero");
    step(18'h15555, 4'b0000, 18'h0F0F0, 4'b0000, "R8 storage zero");
    // transparent
    step(18'h12345, 4'b0001, 18'h0ABCD, 4'b0001, "R2 transparent");
    step(18'h01111, 4'b0001, 18'h02222, 4'b0001, "R2 transparent");
    step(18'h3FFFF, 4'b0001, 18'h00001, 4'b0001, "R2 transparent");
    // latch falls: keep last passed word
    step(18'h00F0F, 4'b0000, 18'h0F0F0, 4'b0000, "R6 latch close");
    step(18'h2D2D2, 4'b0000, 18'h1E1E1, 4'b0000, "R3 hold");
    step(18'h00000, 4'b0000, 18'h3FFFF, 4'b0000, "R3 hold");
    // rising transfer clock, data moves right after
    step(18'h15555, 4'b0010, 18'h0AAAA, 4'b0000, "R4 capture A");
    step(18'h00000, 4'b0010, 18'h0AAAA, 4'b0010, "R4 capture B, R1 independent");
    step(18'h3C3C3, 4'b0010, 18'h11111, 4'b0010, "R4 capture");
    step(18'h3C3C3, 4'b0010, 18'h11111, 4'b0010, "R4 clock held high");
    // falling edges
    step(18'h01234, 4'b0000, 18'h04321, 4'b0000, "R9 falling edge");
    step(18'h05678, 4'b0000, 18'h08765, 4'b0000, "R9 falling edge");
    step(18'h05678, 4'b0000, 18'h08765, 4'b0000, "R9 falling edge");
    // clock enable blocked
    step(18'h11111, 4'b0100, 18'h22222, 4'b0100, "R5 cken high");
    step(18'h11111, 4'b0110, 18'h22222, 4'b0110, "R5 edge ignored");
    step(18'h33333, 4'b0110, 18'h00044, 4'b0110, "R5 edge ignored");
    step(18'h33333, 4'b0100, 18'h00044, 4'b0100, "R5 edge ignored");
    step(18'h33333, 4'b0000, 18'h00044, 4'b0000, "R5 edge ignored");
    // disabled output while capturing; other direction transparent
    step(18'h2468A, 4'b1000, 18'h13579, 4'b0001, "R7 disabled, R1");
    step(18'h2468A, 4'b1010, 18'h0BEEF, 4'b0001, "R7 capture while off, R1");
    step(18'h00007, 4'b1010, 18'h0CAFE, 4'b0001, "R7 capture while off");
    step(18'h00007, 4'b1000, 18'h0CAFE, 4'b0000, "R7 still off");
    step(18'h00009, 4'b0000, 18'h00ACE, 4'b0000, "R7 re-enabled shows capture");
    step(18'h00009, 4'b0000, 18'h00ACE, 4'b1000, "R7 port A off, R1");
    // latch falls in same cycle clock rises
    step(18'h0AAA0, 4'b0001, 18'h05550, 4'b0001, "R2 transparent");
    step(18'h0BBB0, 4'b0010, 18'h06660, 4'b0010, "R4 edge with latch fall");
    step(18'h0CCC0, 4'b0010, 18'h07770, 4'b0010, "R4 edge with latch fall");
    step(18'h0CCC0, 4'b0000, 18'h07770, 4'b0000, "R3 hold");
    step(18'h0CCC0, 4'b1000, 18'h07770, 4'b1000, "R7 both off");

    repeat (3) @(posedge clk);
    #2;
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule